// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block sits beside the receive and transmit datapaths of a 16550-style UART and turns their interrupt conditions into one identification value and one interrupt request line. Its inputs are the condition signals: line status error, receive data ready (or FIFO trigger reached), character timeout, transmit holding register empty, and the four modem input lines. It also takes the four interrupt enable bits and the access strobes for the identification register, the transmit holding register and the modem status register. Each cycle it picks the highest-priority enabled condition and returns its code. It also keeps the two event-type conditions, transmit-empty and modem change, latched until software clears them.

The transmit-empty condition is latched when the holding register goes from full to empty. It is cleared when the holding register is written. It is also cleared when the identification register is read, but only if that read returned the transmit-empty code. A change on any modem line is latched until the modem status register is read. While a read strobe on the identification register is high, the returned value is frozen, so the clear decision is based on the value software actually saw.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_id` is 4'b0001 and `irq` is 0.
- R2: `iir_id[0]` is 0 when an enabled source is pending and 1 when none is. `iir_id[3:1]` holds the code of the reported source: 011 for line status error, 010 for receive data, 110 for character timeout, 001 for transmit empty, 000 for modem change. The value follows the level sources one clock after they change.
- R3: Priority, from highest to lowest, is: line status error, receive data, character timeout, transmit empty, modem change. Receive data wins over timeout when both are present.
- R4: Enable bit `ier[0]` gates receive data and timeout, `ier[1]` gates transmit empty, `ier[2]` gates line status and `ier[3]` gates modem change. A source whose enable bit is 0 does not affect `iir_id` or `irq`.
- R5: A 0-to-1 transition of `thr_empty` sets the transmit-empty latch. The 001 code appears two clocks after the transition.
- R6: A `thr_wr` pulse clears the transmit-empty latch.
- R7: An `iir_rd` pulse clears the transmit-empty latch only while `iir_id` shows code 001. Otherwise the latch keeps its state.
- R8: A change on any bit of `modem_lines` sets the modem latch. Only an `msr_rd` pulse clears it, and a read of `iir_id` leaves it set. The latch records changes even while `ier[3]` is 0.
- R9: While `iir_rd` is high, `iir_id` keeps its value.
- R10: `irq` is 1 one clock after any enabled source is pending, and 0 one clock after none is. `irq` is not frozen by `iir_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ls_err | input | 1 | Line status error condition (level) |
| rx_ready | input | 1 | Receive data ready or trigger reached (level) |
| rx_timeout | input | 1 | Character timeout condition (level) |
| thr_empty | input | 1 | Transmit holding register is empty (level) |
| modem_lines | input | MODEM_W | Modem input lines (CTS, DSR, RI, DCD) |
| ier | input | 4 | Interrupt enable bits |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_id | output | 4 | Identification value: bit 0 is the active-low pending flag, bits 3:1 are the code |
| irq | output | 1 | Interrupt request, active high |

## Verification
Level sources and enable changes show at the ports one clock after they are applied. Latch-based results need two clocks: a `thr_empty` rise, a modem line change, and the effect of a clearing strobe. A frozen read holds `iir_id` for every clock edge at which `iir_rd` is high. The bench changes inputs on falling edges and samples on a later falling edge. It waits exactly one or two rising edges, matching the register path of each result, so every check sees the settled value of the cycle in which the result is due.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int MODEM_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ls_err,
  input  logic               rx_ready,
  input  logic               rx_timeout,
  input  logic               thr_empty,
  input  logic [MODEM_W-1:0] modem_lines,
  input  logic [3:0]         ier,
  input  logic               iir_rd,
  input  logic               thr_wr,
  input  logic               msr_rd,
  output logic [3:0]         iir_id,
  output logic               irq
);
  localparam logic [2:0] CODE_LS = 3'b011;
  localparam logic [2:0] CODE_RX = 3'b010;
  localparam logic [2:0] CODE_TO = 3'b110;
  localparam logic [2:0] CODE_TX = 3'b001;
  localparam logic [2:0] CODE_MS = 3'b000;
  localparam logic [3:0] ID_IDLE = 4'b0001;

  logic               thr_empty_q;
  logic [MODEM_W-1:0] modem_q;
  logic               thre_flag;
  logic               msr_flag;
  logic [3:0]         id_q;
  logic [3:0]         id_next;
  logic               irq_q;

  wire thre_rise   = thr_empty & ~thr_empty_q;
  wire modem_chg   = |(modem_lines ^ modem_q);
  wire tx_read_clr = iir_rd & (id_q == {CODE_TX, 1'b0});
  wire any_pend    = ~id_next[0];

  always_comb begin
    if (ls_err && ier[2])         id_next = {CODE_LS, 1'b0};
    else if (rx_ready && ier[0])  id_next = {CODE_RX, 1'b0};
    else if (rx_timeout && ier[0]) id_next = {CODE_TO, 1'b0};
    else if (thre_flag && ier[1]) id_next = {CODE_TX, 1'b0};
    else if (msr_flag && ier[3])  id_next = {CODE_MS, 1'b0};
    else                          id_next = ID_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_empty_q <= 1'b1;
      modem_q     <= '0;
      thre_flag   <= 1'b0;
      msr_flag    <= 1'b0;
      id_q        <= ID_IDLE;
      irq_q       <= 1'b0;
    end else begin
      thr_empty_q <= thr_empty;
      modem_q     <= modem_lines;
      if (thre_rise)                   thre_flag <= 1'b1;
      else if (thr_wr || tx_read_clr)  thre_flag <= 1'b0;
      if (modem_chg)                   msr_flag <= 1'b1;
      else if (msr_rd)                 msr_flag <= 1'b0;
      if (!iir_rd)                     id_q <= id_next;
      irq_q <= any_pend;
    end
  end

  assign iir_id = id_q;
  assign irq    = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int MODEM_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ls_err,
  input logic               thr_empty,
  input logic               thr_empty_q,
  input logic [MODEM_W-1:0] modem_lines,
  input logic [MODEM_W-1:0] modem_q,
  input logic [3:0]         ier,
  input logic               iir_rd,
  input logic               thr_wr,
  input logic               msr_rd,
  input logic               thre_flag,
  input logic               msr_flag,
  input logic [3:0]         iir_id,
  input logic               irq
);
  AST_HOLD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) iir_rd |=> $stable(iir_id)); // R9
  AST_LS_WINS: assert property (@(posedge clk) disable iff (!rst_n) (ls_err && ier[2] && !iir_rd) |=> iir_id == 4'b0110); // R3
  AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (thr_wr && !(thr_empty && !thr_empty_q)) |=> !thre_flag); // R6
  AST_MSR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (msr_flag && !msr_rd) |=> msr_flag); // R8
  AST_MSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (msr_rd && modem_lines == modem_q) |=> !msr_flag); // R8
  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n) !iir_rd |=> (iir_id[0] == !irq)); // R10
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    iir_id inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000}); // R2
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.MODEM_W(MODEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ls_err(ls_err), .thr_empty(thr_empty),
  .thr_empty_q(thr_empty_q), .modem_lines(modem_lines), .modem_q(modem_q),
  .ier(ier), .iir_rd(iir_rd), .thr_wr(thr_wr), .msr_rd(msr_rd),
  .thre_flag(thre_flag), .msr_flag(msr_flag), .iir_id(iir_id), .irq(irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ls_err = 0, rx_ready = 0, rx_timeout = 0, thr_empty = 1;
  logic [3:0] modem_lines = '0;
  logic [3:0] ier = '0;
  logic       iir_rd = 0, thr_wr = 0, msr_rd = 0;
  logic [3:0] iir_id;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.MODEM_W(4)) u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ls_err(ls_err), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .thr_empty(thr_empty), .modem_lines(modem_lines),
    .ier(ier), .iir_rd(iir_rd), .thr_wr(thr_wr), .msr_rd(msr_rd),
    .iir_id(iir_id), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [3:0] exp_id, input logic exp_irq);
    checks++;
    if (iir_id !== exp_id || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: iir_id=%b irq=%b expected iir_id=%b irq=%b", req, iir_id, irq, exp_id, exp_irq);
    end
  endtask

  task automatic raise_thre();
    thr_empty = 0; tick(1);
    thr_empty = 1; tick(2);
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 4'b0001, 1'b0);
  endtask

  task automatic t_priority();
    ier = 4'hF; ls_err = 1; rx_ready = 1; rx_timeout = 1; tick(1);
    expect_out("R3 line status first", 4'b0110, 1'b1);
    ls_err = 0; tick(1);
    expect_out("R3 rx data over timeout", 4'b0100, 1'b1);
    rx_ready = 0; tick(1);
    expect_out("R2 timeout code", 4'b1100, 1'b1);
    rx_timeout = 0; tick(1);
    expect_out("R10 idle drops irq", 4'b0001, 1'b0);
  endtask

  task automatic t_enable();
    ier = 4'b1011; ls_err = 1; tick(1);
    expect_out("R4 line status masked", 4'b0001, 1'b0);
    ier = 4'hF; tick(1);
    expect_out("R4 line status enabled", 4'b0110, 1'b1);
    ls_err = 0; ier = 4'b1110; rx_ready = 1; tick(1);
    expect_out("R4 rx data masked", 4'b0001, 1'b0);
    rx_ready = 0; ier = 4'hF; tick(1);
  endtask

  task automatic t_thre_write();
    raise_thre();
    expect_out("R5 transmit empty latched", 4'b0010, 1'b1);
    thr_wr = 1; tick(1);
    thr_wr = 0; tick(1);
    expect_out("R6 write clears transmit empty", 4'b0001, 1'b0);
  endtask

  task automatic t_thre_read();
    raise_thre();
    iir_rd = 1; tick(1);
    expect_out("R9 value held in read", 4'b0010, 1'b1);
    iir_rd = 0; tick(1);
    expect_out("R7 reported read clears", 4'b0001, 1'b0);
    raise_thre();
    rx_ready = 1; tick(1);
    expect_out("R3 rx data over transmit empty", 4'b0100, 1'b1);
    iir_rd = 1; tick(1);
    iir_rd = 0; rx_ready = 0; tick(1);
    expect_out("R7 unreported read keeps latch", 4'b0010, 1'b1);
    thr_wr = 1; tick(1);
    thr_wr = 0; tick(1);
    expect_out("R6 cleanup", 4'b0001, 1'b0);
  endtask

  task automatic t_freeze();
    iir_rd = 1; ls_err = 1; tick(2);
    expect_out("R9 frozen while read high, R10 irq live", 4'b0001, 1'b1);
    iir_rd = 0; tick(1);
    expect_out("R9 released", 4'b0110, 1'b1);
    ls_err = 0; tick(1);
  endtask

  task automatic t_modem();
    modem_lines[0] = 1; tick(2);
    expect_out("R8 modem change latched", 4'b0000, 1'b1);
    iir_rd = 1; tick(1);
    iir_rd = 0; tick(1);
    expect_out("R8 identification read keeps modem", 4'b0000, 1'b1);
    raise_thre();
    expect_out("R3 transmit empty over modem", 4'b0010, 1'b1);
    thr_wr = 1; tick(1);
    thr_wr = 0; tick(1);
    expect_out("R3 modem lowest", 4'b0000, 1'b1);
    msr_rd = 1; tick(1);
    msr_rd = 0; tick(1);
    expect_out("R8 modem read clears", 4'b0001, 1'b0);
    ier = 4'b0111; modem_lines[2] = 1; tick(2);
    expect_out("R4 modem masked", 4'b0001, 1'b0);
    ier = 4'hF; tick(1);
    expect_out("R8 latched while masked", 4'b0000, 1'b1);
    msr_rd = 1; tick(1);
    msr_rd = 0; tick(1);
    expect_out("R8 cleared again", 4'b0001, 1'b0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_priority();
    t_enable();
    t_thre_write();
    t_thre_read();
    t_freeze();
    t_modem();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule